// File: doc/BRIEF.md
# Time-Limited Read Prefetch Cache

This block sits in a bridge between an upstream initiator that reads memory and a downstream target that supplies the data. When the initiator opens a read, the block fetches words from the target ahead of demand, up to a programmable depth. It returns those words to the initiator in address order from a circular word buffer. A plain bridge throws away whatever prefetched data is left when the initiator ends its read. This block can instead keep that data, and can go on fetching until the buffer holds the programmed amount.

If the initiator soon opens a new read at exactly the next address it has not yet received, the block serves that read from the held words. It does not restart the target fetch. The held words are dropped after a fixed idle window, on any other read address, on a write that lands inside the held range, or when retention is switched off. Retention works only when both enable inputs are set and the target bus is in conventional mode. It applies to every address; there is no per-device control.

Top module: `rdhold_cache`

## Requirements
- R1: Each beat on `ini_beat` returns the word the target delivered for the next byte address of the read, starting at the read's start address and stepping by 4. The two low address bits are ignored. A beat is offered only while a read is open and at least one fetched word is buffered.
- R2: Retention is active only when `cfg_keep_en`=1, `cfg_keep_arm`=1 and `cfg_ext_mode`=0. When it is inactive, ending a read drops all buffered words and stops target fetches, so the next read at the following address does not hit.
- R3: While a read is open or data is held, the block requests target words whenever the buffered word count is below the limit, and never when it is at the limit. After a read ends with retention active, fetching continues until the buffer holds exactly the limit.
- R4: The limit in words is taken from `cfg_pf_size`: code 0=16 (64 bytes), 1=32, 2=64, 3=128, 4=256 (1024 bytes), and codes 5, 6 and 7 give 256.
- R5: A new read whose word address equals the next unreturned held address, while data is held, raises `ini_hit` in the start cycle. It keeps the buffer, and its first beats come from the held words.
- R6: A read that does not hit, including any read started while another read is open, drops the buffer, lowers `ini_hit` and fetches afresh from the new address.
- R7: The idle count starts at 0 in the cycle after a read ends and rises by one each held cycle. A read started while the count is 64 or less can still hit. When the count is 64 and no read starts, the held words are dropped at the next edge. A read sampled on the 65th edge after the ending edge hits; one sampled on the 66th misses.
- R8: A write (`ini_wr`) to a word address from the next unreturned address up to, but not including, the next fetch address drops held data. If the write comes while a read is open, the buffered words are discarded and refetched starting at the next unreturned address. A write outside that range changes nothing.
- R9: Clearing either enable or selecting extended mode while data is held drops the held words at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_keep_en | input | 1 | First retention enable |
| cfg_keep_arm | input | 1 | Second retention enable |
| cfg_ext_mode | input | 1 | 1 = target bus in extended mode (no retention) |
| cfg_pf_size | input | 3 | Prefetch limit code |
| ini_rd_start | input | 1 | Initiator opens a read this cycle |
| ini_rd_addr | input | 32 | Byte start address of the read |
| ini_rd_ready | input | 1 | Initiator accepts a beat this cycle |
| ini_rd_done | input | 1 | Initiator ends its open read |
| ini_wr | input | 1 | Initiator write strobe |
| ini_wr_addr | input | 32 | Byte address of the write |
| ini_beat | output | 1 | A data beat is returned this cycle |
| ini_data | output | 32 | Beat data |
| ini_hit | output | 1 | The starting read is served from held data |
| tgt_fetch_req | output | 1 | Request for one target word |
| tgt_fetch_addr | output | 32 | Byte address of the requested word |
| tgt_data_valid | input | 1 | Target delivers the requested word |
| tgt_data | input | 32 | Target word |

## Verification
Properties check on every cycle that fetch requests never occur with the buffer at its limit and that beats never come from an empty buffer. They also check that a hit keeps the head address while a miss resets it. On the control side, they check that disabling, expiry, an overlapping write and an ending read without retention each drop held data one edge later. Only the bench scenarios can show the data values and their order, the total fetched for each limit code, and the exact 65/66 edge boundary of the idle window. They also show that a write outside the held range leaves a later hit intact, and that a refetch after a write during an open read keeps returning correct data.

// File: rtl/rdhold_pkg.sv
`timescale 1ns/1ps
package rdhold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LIVE = 2'd1,
        ST_HOLD = 2'd2
    } hold_state_e;
endpackage

// File: rtl/rdhold_limit_dec.sv
`timescale 1ns/1ps
module rdhold_limit_dec #(
    parameter int CODE_W     = 3,
    parameter int BASE_WORDS = 16,
    parameter int DEPTH      = 256,
    parameter int CNT_W      = 9
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit_words
);
    localparam int NCODE = 1 << CODE_W;

    logic [CNT_W-1:0] table_w [NCODE];

    // each code doubles the depth, clamped at the buffer size
    for (genvar g = 0; g < NCODE; g++) begin : g_code
        localparam int RAW = BASE_WORDS << g;
        localparam int LIM = (RAW > DEPTH) ? DEPTH : RAW;
        assign table_w[g] = CNT_W'(LIM);
    end

    assign limit_words = table_w[code];
endmodule

// File: rtl/rdhold_store.sv
`timescale 1ns/1ps
module rdhold_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_ptr];
endmodule

// File: rtl/rdhold_idle.sv
`timescale 1ns/1ps
module rdhold_idle #(
    parameter int LIMIT = 64,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || clear) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt    = cnt_q;
    assign expire = run && (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/rdhold_cache.sv
`timescale 1ns/1ps
module rdhold_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SIZE_W     = 3,
    parameter int BASE_BYTES = 64,
    parameter int MAX_BYTES  = 1024,
    parameter int IDLE_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_keep_en,
    input  logic              cfg_keep_arm,
    input  logic              cfg_ext_mode,
    input  logic [SIZE_W-1:0] cfg_pf_size,
    input  logic              ini_rd_start,
    input  logic [ADDR_W-1:0] ini_rd_addr,
    input  logic              ini_rd_ready,
    input  logic              ini_rd_done,
    input  logic              ini_wr,
    input  logic [ADDR_W-1:0] ini_wr_addr,
    output logic              ini_beat,
    output logic [DATA_W-1:0] ini_data,
    output logic              ini_hit,
    output logic              tgt_fetch_req,
    output logic [ADDR_W-1:0] tgt_fetch_addr,
    input  logic              tgt_data_valid,
    input  logic [DATA_W-1:0] tgt_data
);
    import rdhold_pkg::*;

    localparam int BYTES_W    = DATA_W / 8;
    localparam int OFS_W      = $clog2(BYTES_W);
    localparam int WA_W       = ADDR_W - OFS_W;
    localparam int DEPTH      = MAX_BYTES / BYTES_W;
    localparam int BASE_WORDS = BASE_BYTES / BYTES_W;
    localparam int PTR_W      = $clog2(DEPTH);
    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int IDLE_W     = $clog2(IDLE_LIMIT + 1);

    typedef struct packed {
        hold_state_e      st;
        logic [WA_W-1:0]  head_wa;
        logic [WA_W-1:0]  fetch_wa;
        logic [PTR_W-1:0] hptr;
        logic [PTR_W-1:0] tptr;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_q, r_d;

    logic [CNT_W-1:0]  limit_words;
    logic [IDLE_W-1:0] idle_cnt;
    logic              idle_expire;
    logic              retain_ok;
    logic              take;
    logic              hit;
    logic              wr_overlap;
    logic [WA_W-1:0]   rd_wa;
    logic [WA_W-1:0]   wr_wa;
    logic [DATA_W-1:0] head_word;

    rdhold_limit_dec #(
        .CODE_W     (SIZE_W),
        .BASE_WORDS (BASE_WORDS),
        .DEPTH      (DEPTH),
        .CNT_W      (CNT_W)
    ) u_limit (
        .code        (cfg_pf_size),
        .limit_words (limit_words)
    );

    rdhold_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (take),
        .wr_ptr  (r_q.tptr),
        .wr_data (tgt_data),
        .rd_ptr  (r_q.hptr),
        .rd_data (head_word)
    );

    rdhold_idle #(
        .LIMIT (IDLE_LIMIT),
        .CW    (IDLE_W)
    ) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.st == ST_HOLD),
        .clear  (ini_beat),
        .cnt    (idle_cnt),
        .expire (idle_expire)
    );

    assign retain_ok = cfg_keep_en && cfg_keep_arm && !cfg_ext_mode;
    assign rd_wa     = ini_rd_addr[ADDR_W-1:OFS_W];
    assign wr_wa     = ini_wr_addr[ADDR_W-1:OFS_W];

    assign hit = ini_rd_start && (r_q.st == ST_HOLD) && (r_q.cnt != '0)
                 && (rd_wa == r_q.head_wa);

    assign ini_beat = (r_q.st == ST_LIVE) && ini_rd_ready && (r_q.cnt != '0)
                      && !ini_rd_start;
    assign ini_data = head_word;
    assign ini_hit  = hit;

    assign tgt_fetch_req  = (r_q.st != ST_IDLE) && (r_q.cnt < limit_words);
    assign tgt_fetch_addr = {r_q.fetch_wa, {OFS_W{1'b0}}};
    assign take           = tgt_fetch_req && tgt_data_valid;

    assign wr_overlap = ini_wr && (r_q.st != ST_IDLE)
                        && (wr_wa >= r_q.head_wa) && (wr_wa < r_q.fetch_wa);

    always_comb begin
        r_d = r_q;

        // buffer movement: one word in from the target, one word out to the initiator
        if (take) begin
            r_d.tptr     = r_q.tptr + PTR_W'(1);
            r_d.fetch_wa = r_q.fetch_wa + WA_W'(1);
        end
        if (ini_beat) begin
            r_d.hptr    = r_q.hptr + PTR_W'(1);
            r_d.head_wa = r_q.head_wa + WA_W'(1);
        end
        r_d.cnt = r_q.cnt + CNT_W'(take) - CNT_W'(ini_beat);

        if (ini_rd_start) begin
            r_d.st = ST_LIVE;
            if (!hit) begin
                r_d.head_wa  = rd_wa;
                r_d.fetch_wa = rd_wa;
                r_d.hptr     = '0;
                r_d.tptr     = '0;
                r_d.cnt      = '0;
            end
        end else begin
            if ((r_q.st == ST_LIVE) && ini_rd_done) begin
                if (retain_ok) begin
                    r_d.st = ST_HOLD;
                end else begin
                    r_d.st   = ST_IDLE;
                    r_d.hptr = '0;
                    r_d.tptr = '0;
                    r_d.cnt  = '0;
                end
            end else if ((r_q.st == ST_HOLD) && (!retain_ok || idle_expire)) begin
                r_d.st   = ST_IDLE;
                r_d.hptr = '0;
                r_d.tptr = '0;
                r_d.cnt  = '0;
            end

            if (wr_overlap) begin
                if (r_d.st == ST_LIVE) begin
                    // keep the read open, refetch from the next unreturned word
                    r_d.fetch_wa = r_d.head_wa;
                    r_d.tptr     = r_d.hptr;
                    r_d.cnt      = '0;
                end else begin
                    r_d.st   = ST_IDLE;
                    r_d.hptr = '0;
                    r_d.tptr = '0;
                    r_d.cnt  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.head_wa  <= '0;
            r_q.fetch_wa <= '0;
            r_q.hptr     <= '0;
            r_q.tptr     <= '0;
            r_q.cnt      <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rdhold_cache_chk.sv
`timescale 1ns/1ps
module rdhold_cache_chk #(
    parameter int WA_W       = 30,
    parameter int CNT_W      = 9,
    parameter int IDLE_W     = 7,
    parameter int IDLE_LIMIT = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input rdhold_pkg::hold_state_e st,
    input logic [WA_W-1:0]         head_wa,
    input logic [WA_W-1:0]         fetch_wa,
    input logic [CNT_W-1:0]        cnt,
    input logic [CNT_W-1:0]        limit_words,
    input logic [IDLE_W-1:0]       idle_cnt,
    input logic                    retain_ok,
    input logic [WA_W-1:0]         rd_wa,
    input logic [WA_W-1:0]         wr_wa,
    input logic                    ini_rd_start,
    input logic                    ini_rd_done,
    input logic                    ini_wr,
    input logic                    ini_beat,
    input logic                    ini_hit,
    input logic                    tgt_fetch_req
);
    import rdhold_pkg::*;

    AST_FETCH_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_fetch_req |-> (cnt < limit_words)); // R3

    AST_BEAT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ini_beat |-> ((cnt != '0) && (st == ST_LIVE))); // R1

    AST_HIT_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ini_hit |=> ((head_wa == $past(rd_wa)) && (st == ST_LIVE))); // R5

    AST_MISS_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ini_rd_start && !ini_hit) |=> ((cnt == '0) && (fetch_wa == $past(rd_wa)))); // R6

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ini_rd_done && (st == ST_LIVE) && !retain_ok && !ini_rd_start)
        |=> ((st == ST_IDLE) && !tgt_fetch_req)); // R2

    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (idle_cnt <= IDLE_W'(IDLE_LIMIT))); // R7

    AST_EXPIRE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HOLD) && (idle_cnt == IDLE_W'(IDLE_LIMIT)) && !ini_rd_start)
        |=> (st == ST_IDLE)); // R7

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HOLD) && !retain_ok && !ini_rd_start) |=> (st == ST_IDLE)); // R9

    AST_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HOLD) && ini_wr && (wr_wa >= head_wa) && (wr_wa < fetch_wa)
         && !ini_rd_start) |=> (st == ST_IDLE)); // R8
endmodule

bind rdhold_cache rdhold_cache_chk #(
    .WA_W       (WA_W),
    .CNT_W      (CNT_W),
    .IDLE_W     (IDLE_W),
    .IDLE_LIMIT (IDLE_LIMIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st            (r_q.st),
    .head_wa       (r_q.head_wa),
    .fetch_wa      (r_q.fetch_wa),
    .cnt           (r_q.cnt),
    .limit_words   (limit_words),
    .idle_cnt      (idle_cnt),
    .retain_ok     (retain_ok),
    .rd_wa         (rd_wa),
    .wr_wa         (wr_wa),
    .ini_rd_start  (ini_rd_start),
    .ini_rd_done   (ini_rd_done),
    .ini_wr        (ini_wr),
    .ini_beat      (ini_beat),
    .ini_hit       (ini_hit),
    .tgt_fetch_req (tgt_fetch_req)
);

// File: tb/sim_rdhold_cache.sv
`timescale 1ns/1ps
module sim_rdhold_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_keep_en = 1'b1;
    logic        cfg_keep_arm = 1'b1;
    logic        cfg_ext_mode = 1'b0;
    logic [2:0]  cfg_pf_size = 3'd1;
    logic        ini_rd_start = 1'b0;
    logic [31:0] ini_rd_addr = '0;
    logic        ini_rd_ready = 1'b0;
    logic        ini_rd_done = 1'b0;
    logic        ini_wr = 1'b0;
    logic [31:0] ini_wr_addr = '0;
    logic        ini_beat;
    logic [31:0] ini_data;
    logic        ini_hit;
    logic        tgt_fetch_req;
    logic [31:0] tgt_fetch_addr;
    logic        tgt_data_valid;
    logic [31:0] tgt_data;

    int   total = 0;
    int   bad = 0;
    int   nfetch = 0;
    int   base = 0;
    int   cyc = 0;
    logic stall_on = 1'b0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction

    function automatic int limit_of(input int code);
        int w;
        w = 16 << code;
        if (w > 256) w = 256;
        return w;
    endfunction

    assign tgt_data       = word_of(tgt_fetch_addr);
    assign tgt_data_valid = stall_on ? (cyc % 3 != 0) : 1'b1;

    always @(negedge clk) cyc = cyc + 1;
    always @(posedge clk) if (tgt_fetch_req && tgt_data_valid) nfetch = nfetch + 1;

    rdhold_cache u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_keep_en    (cfg_keep_en),
        .cfg_keep_arm   (cfg_keep_arm),
        .cfg_ext_mode   (cfg_ext_mode),
        .cfg_pf_size    (cfg_pf_size),
        .ini_rd_start   (ini_rd_start),
        .ini_rd_addr    (ini_rd_addr),
        .ini_rd_ready   (ini_rd_ready),
        .ini_rd_done    (ini_rd_done),
        .ini_wr         (ini_wr),
        .ini_wr_addr    (ini_wr_addr),
        .ini_beat       (ini_beat),
        .ini_data       (ini_data),
        .ini_hit        (ini_hit),
        .tgt_fetch_req  (tgt_fetch_req),
        .tgt_fetch_addr (tgt_fetch_addr),
        .tgt_data_valid (tgt_data_valid),
        .tgt_data       (tgt_data)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // open a read; check the hit flag in the start cycle
    task automatic start_read(input logic [31:0] a, input logic exp_hit, input string req);
        ini_rd_addr  = a;
        ini_rd_start = 1'b1;
        #1;
        chk(ini_hit == exp_hit, req, 32'(ini_hit), 32'(exp_hit));
        @(negedge clk);
        ini_rd_start = 1'b0;
        base = nfetch;
    endtask

    // take n beats starting at byte address a, checking each word
    task automatic take_beats(input logic [31:0] a, input int n, input string req);
        int got;
        int guard;
        got = 0;
        guard = 0;
        ini_rd_ready = 1'b1;
        while (got < n && guard < 3000) begin
            #1;
            if (ini_beat) begin
                chk(ini_data == word_of(a + 32'(4 * got)), req, ini_data,
                    word_of(a + 32'(4 * got)));
                got = got + 1;
            end
            @(negedge clk);
            guard = guard + 1;
        end
        ini_rd_ready = 1'b0;
        chk(got == n, req, 32'(got), 32'(n));
    endtask

    task automatic end_read();
        ini_rd_done = 1'b1;
        @(negedge clk);
        ini_rd_done = 1'b0;
    endtask

    // next start is sampled on the j-th edge after the ending edge
    task automatic gap(input int j);
        repeat (j - 1) @(negedge clk);
    endtask

    task automatic write_at(input logic [31:0] a);
        ini_wr_addr = a;
        ini_wr = 1'b1;
        @(negedge clk);
        ini_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        #1;
        chk(tgt_fetch_req == 1'b0, "reset R3", 32'(tgt_fetch_req), 0);
        chk(ini_beat == 1'b0, "reset R1", 32'(ini_beat), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 with target stalls, then R5 hit on the following address
        stall_on = 1'b1;
        cfg_pf_size = 3'd1;
        start_read(32'h0000_1000, 1'b0, "R6 first read");
        take_beats(32'h0000_1000, 4, "R1 stalled data");
        end_read();
        stall_on = 1'b0;
        gap(10);
        start_read(32'h0000_1010, 1'b1, "R5 hit flag");
        take_beats(32'h0000_1010, 8, "R5 hit data");
        end_read();

        // R6 miss, then R3 continued fetch after end
        gap(5);
        start_read(32'h0000_2003, 1'b0, "R6 miss flag");
        take_beats(32'h0000_2000, 3, "R6 miss data");
        end_read();
        repeat (45) @(negedge clk);
        chk(nfetch - base == 3 + 32, "R3 fill after end", 32'(nfetch - base), 35);

        // R2: each way of switching retention off
        for (int v = 0; v < 3; v++) begin
            cfg_keep_en  = (v != 0);
            cfg_keep_arm = (v != 1);
            cfg_ext_mode = (v == 2);
            start_read(32'h0000_3000 + 32'(v * 32'h100), 1'b0, "R2 start");
            take_beats(32'h0000_3000 + 32'(v * 32'h100), 3, "R2 data");
            end_read();
            snap = nfetch;
            repeat (30) @(negedge clk);
            chk(nfetch == snap, "R2 no fetch after end", 32'(nfetch), 32'(snap));
            start_read(32'h0000_300C + 32'(v * 32'h100), 1'b0, "R2 no hit");
            end_read();
        end
        cfg_keep_en = 1'b1;
        cfg_keep_arm = 1'b1;
        cfg_ext_mode = 1'b0;

        // R4: sweep every limit code
        for (int c = 0; c < 8; c++) begin
            cfg_pf_size = 3'(c);
            start_read(32'h0001_0000 + 32'(c * 32'h1000), 1'b0, "R4 start");
            repeat (300) @(negedge clk);
            chk(nfetch - base == limit_of(c), "R4 limit code", 32'(nfetch - base),
                32'(limit_of(c)));
            take_beats(32'h0001_0000 + 32'(c * 32'h1000), 2, "R4 data");
            end_read();
        end

        // R7 idle window boundary
        cfg_pf_size = 3'd1;
        start_read(32'h0002_0000, 1'b0, "R7 start");
        take_beats(32'h0002_0000, 2, "R7 data");
        end_read();
        gap(65);
        start_read(32'h0002_0008, 1'b1, "R7 hit at edge 65");
        take_beats(32'h0002_0008, 2, "R7 data after late hit");
        end_read();
        gap(66);
        start_read(32'h0002_0010, 1'b0, "R7 miss at edge 66");
        take_beats(32'h0002_0010, 2, "R7 data after expiry");
        end_read();

        // R8 writes against held data
        gap(3);
        start_read(32'h0003_0000, 1'b0, "R8 start");
        take_beats(32'h0003_0000, 4, "R8 data");
        end_read();
        gap(3);
        write_at(32'h0003_0018);
        start_read(32'h0003_0010, 1'b0, "R8 overlap write drops");
        take_beats(32'h0003_0010, 2, "R8 data after drop");
        end_read();
        gap(3);
        write_at(32'h0002_FFFC);
        start_read(32'h0003_0018, 1'b1, "R8 outside write keeps");
        take_beats(32'h0003_0018, 2, "R8 data kept");
        end_read();

        // R8 write during an open read: refetch
        cfg_pf_size = 3'd0;
        start_read(32'h0004_0000, 1'b0, "R8 live start");
        repeat (20) @(negedge clk);
        chk(nfetch - base == 16, "R8 live fill", 32'(nfetch - base), 16);
        write_at(32'h0004_0008);
        repeat (30) @(negedge clk);
        chk(nfetch - base == 32, "R8 live refetch", 32'(nfetch - base), 32);
        take_beats(32'h0004_0000, 4, "R8 live data");
        end_read();

        // R9 disable while holding
        cfg_pf_size = 3'd1;
        gap(3);
        start_read(32'h0005_0000, 1'b0, "R9 start");
        take_beats(32'h0005_0000, 2, "R9 data");
        end_read();
        gap(3);
        cfg_keep_en = 1'b0;
        @(negedge clk);
        cfg_keep_en = 1'b1;
        start_read(32'h0005_0008, 1'b0, "R9 dropped on disable");
        take_beats(32'h0005_0008, 2, "R9 data after drop");
        end_read();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule